// File: doc/BRIEF.md
# Command Controller Register Stub

This block is the software-facing register window of a command controller whose wire side is absent. A host issues a command by setting a single trigger bit. The block finishes that command in the same clock edge. It places a fixed success completion code (0x40) into the first word of both the outgoing and the incoming data buffers. It records a done flag in the status register, masked by the interrupt enable register, and raises a level interrupt when the masked result is nonzero.

Access uses a plain 32-bit register bus: a byte address, a write strobe, write data and combinational read data. The register array holds a parameterised number of 32-bit words. Addresses past the array are inert: writes to them do nothing and reads from them return zero. The two low address bits are ignored, so all accesses are word accesses. Firmware must clear pending status, by writing ones to the status word, before the next trigger is accepted.

Top module: `cmd_stub_regs`

## Requirements
- R1: After reset every word of the array reads 0 and `irq_o` is 0.
- R2: A write to any in-range word other than the command word (byte offset 0x08) and the status word (0x1C) stores all 32 bits, and a later read returns them.
- R3: A write at a byte address at or above 4 × NUM_WORDS (0x40 by default) changes no register, and a read there returns 0.
- R4: The command word always reads 0. A command write whose bit 0 is 0 leaves every register and `irq_o` unchanged.
- R5: A command write with bit 0 set while the status word is zero loads 0x40 into the write-data word 0 (0x20) and the read-data word 0 (0x30). The values can be read in the cycle after that edge.
- R6: An accepted trigger replaces the status word with (0x1 AND interrupt enable word at 0x18). Only bit 0 can become set, whatever the other enable bits hold.
- R7: On the same edge as an accepted trigger, `irq_o` goes to 1 when the new status word is nonzero. When it is zero, `irq_o` stays 0.
- R8: A command write with bit 0 set while the status word is nonzero changes no register and leaves `irq_o` unchanged.
- R9: A write to the status word clears each status bit where the written data has a 1. Bits where the data has a 0 are left as they are. `irq_o` drops on the edge where the status word becomes zero.
- R10: Once `irq_o` is high, it stays high until the status word is cleared, even if the interrupt enable word is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_we_i | input | 1 | Write strobe for the current cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The hardest state to reach is a refused trigger. The status word has to be pending with the interrupt high, and the data buffers have to hold values that are distinct from the completion code, so that a wrongly accepted trigger would be visible. The stimulus first fires a trigger with the enable set. It then overwrites both buffer words with marker values and fires again. After that it rewrites the enable to zero and clears the status one bit pattern at a time. At each step it reads the buffers, the status word and `irq_o`.

// File: rtl/cmd_stub_pkg.sv
`timescale 1ns/1ps
package cmd_stub_pkg;
    localparam int DATA_W  = 32;
    // word indices whose behaviour is special
    localparam int CMD_IDX = 2;
    localparam int IEN_IDX = 6;
    localparam int STS_IDX = 7;
    localparam int WR0_IDX = 8;
    localparam int RD0_IDX = 12;

    localparam logic [DATA_W-1:0] CC_SUCCESS = 32'h0000_0040;
    localparam logic [DATA_W-1:0] DONE_FLAG  = 32'h0000_0001;

    typedef struct packed {
        logic              fire;     // trigger bit written as 1
        logic              sts_clr;  // write-one-to-clear on status
        logic              plain_we; // ordinary store
        logic [DATA_W-1:0] wdata;
    } wr_req_t;
endpackage

// File: rtl/cmd_stub_decode.sv
`timescale 1ns/1ps
module cmd_stub_decode
    import cmd_stub_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [NUM_WORDS-1:0] sel_o,
    output logic                 in_range_o,
    output wr_req_t              req_o
);
    localparam int WA_W  = ADDR_W - 2;
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic [WA_W-1:0]  waddr;
    logic [IDX_W-1:0] idx;
    logic             is_cmd;
    logic             is_sts;
    logic [1:0]       unused_lsb;

    assign waddr      = addr_i[ADDR_W-1:2];
    assign unused_lsb = addr_i[1:0];
    assign idx        = waddr[IDX_W-1:0];
    assign in_range_o = (waddr < WA_W'(NUM_WORDS));
    assign is_cmd     = in_range_o && (idx == IDX_W'(CMD_IDX));
    assign is_sts     = in_range_o && (idx == IDX_W'(STS_IDX));

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_sel
        assign sel_o[g] = in_range_o && (idx == IDX_W'(g));
    end

    always_comb begin
        req_o          = '0;
        req_o.wdata    = wdata_i;
        req_o.fire     = we_i && is_cmd && wdata_i[0];
        req_o.sts_clr  = we_i && is_sts;
        req_o.plain_we = we_i && in_range_o && !is_cmd && !is_sts;
    end

    p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(sel_o));
    p_oor_inert_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_range_o |-> (sel_o == '0 && !req_o.fire && !req_o.sts_clr && !req_o.plain_we));
endmodule

// File: rtl/cmd_stub_regfile.sv
`timescale 1ns/1ps
module cmd_stub_regfile
    import cmd_stub_pkg::*;
#(
    parameter int NUM_WORDS = 16
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  wr_req_t                           req_i,
    input  logic [NUM_WORDS-1:0]              sel_i,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]  words_o,
    output logic                              irq_o
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] words;
        logic                             irq;
    } state_t;

    state_t st_d, st_q;
    logic   accept;

    assign accept = req_i.fire && (st_q.words[STS_IDX] == '0);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (req_i.plain_we && sel_i[i]) st_d.words[i] = req_i.wdata;
        end
        if (req_i.sts_clr) begin
            st_d.words[STS_IDX] = st_q.words[STS_IDX] & ~req_i.wdata;
            if (st_d.words[STS_IDX] == '0) st_d.irq = 1'b0;
        end
        if (accept) begin
            st_d.words[RD0_IDX] = CC_SUCCESS;
            st_d.words[WR0_IDX] = CC_SUCCESS;
            st_d.words[STS_IDX] = DONE_FLAG & st_q.words[IEN_IDX];
            if (st_d.words[STS_IDX] != '0) st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign words_o = st_q.words;
    assign irq_o   = st_q.irq;

    p_cmd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.words[CMD_IDX] == '0);
    p_fire_loads_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i.fire && st_q.words[STS_IDX] == '0) |=>
        (st_q.words[RD0_IDX] == CC_SUCCESS && st_q.words[WR0_IDX] == CC_SUCCESS));
    p_sts_overwrite_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i.fire && st_q.words[STS_IDX] == '0) |=>
        (st_q.words[STS_IDX] == (DONE_FLAG & $past(st_q.words[IEN_IDX]))));
    p_fire_refused_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i.fire && st_q.words[STS_IDX] != '0) |=>
        ($stable(st_q.words[RD0_IDX]) && $stable(st_q.words[WR0_IDX]) && $stable(st_q.irq)));
    p_irq_tracks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.irq == (st_q.words[STS_IDX] != '0));
    p_irq_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.irq && !req_i.sts_clr) |=> st_q.irq);
endmodule

// File: rtl/cmd_stub_rdmux.sv
`timescale 1ns/1ps
module cmd_stub_rdmux
    import cmd_stub_pkg::*;
#(
    parameter int NUM_WORDS = 16
) (
    input  logic [NUM_WORDS-1:0][DATA_W-1:0] words_i,
    input  logic [NUM_WORDS-1:0]             sel_i,
    input  logic                             in_range_i,
    output logic [DATA_W-1:0]                rdata_o
);
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (sel_i[i]) rdata_o = rdata_o | words_i[i];
        end
    end

    always_comb begin
        if (!in_range_i) p_oor_reads_zero_r3: assert (sel_i == '0);
    end
endmodule

// File: rtl/cmd_stub_regs.sv
`timescale 1ns/1ps
module cmd_stub_regs
    import cmd_stub_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    logic [NUM_WORDS-1:0]             sel;
    logic                             in_range;
    wr_req_t                          req;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    cmd_stub_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
        .sel_o(sel), .in_range_o(in_range), .req_o(req)
    );

    cmd_stub_regfile #(.NUM_WORDS(NUM_WORDS)) u_regfile (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .req_i(req), .sel_i(sel), .words_o(words), .irq_o(irq_o)
    );

    cmd_stub_rdmux #(.NUM_WORDS(NUM_WORDS)) u_rdmux (
        .words_i(words), .sel_i(sel), .in_range_i(in_range), .rdata_o(bus_rdata_o)
    );

    p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !irq_o);
endmodule

// File: tb/cmd_stub_regs_tb.sv
`timescale 1ns/1ps
module cmd_stub_regs_tb;
    localparam int ADDR_W = 12;
    localparam int NW     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              we = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cmd_stub_regs #(.ADDR_W(ADDR_W), .NUM_WORDS(NW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 check(tag, rdata, exp);
    endtask

    task automatic irq_is(input string tag, input logic exp);
        @(negedge clk);
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'h9E37_79B9 * (i + 1);
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < NW; i++) rd("R1 reset word", ADDR_W'(i * 4), 32'h0);
        irq_is("R1 irq after reset", 1'b0);

        // R2: store and read back every ordinary word
        for (int i = 0; i < NW; i++)
            if (i != 2 && i != 7) wr(ADDR_W'(i * 4), pat(i));
        for (int i = 0; i < NW; i++)
            if (i != 2 && i != 7) rd("R2 readback", ADDR_W'(i * 4), pat(i));

        // R4: command word never stored, bit0=0 inert
        wr(12'h008, 32'hFFFF_FFFE);
        rd("R4 cmd reads zero", 12'h008, 32'h0);
        rd("R4 wr0 untouched", 12'h020, pat(8));
        rd("R4 rd0 untouched", 12'h030, pat(12));
        rd("R4 status untouched", 12'h01C, 32'h0);
        irq_is("R4 irq untouched", 1'b0);

        // R3: out-of-range writes and reads
        for (int a = 'h40; a < 'h1000; a += 'h1C4) begin
            wr(ADDR_W'(a), 32'hDEAD_BEEF);
            rd("R3 oor read", ADDR_W'(a), 32'h0);
        end
        for (int i = 0; i < NW; i++)
            if (i != 2 && i != 7) rd("R3 no alias", ADDR_W'(i * 4), pat(i));

        // R5 R6 R7: fire with enable cleared
        wr(12'h018, 32'h0);
        wr(12'h008, 32'h1);
        check("R7 irq low with mask off", {31'b0, irq}, 32'h0);
        rd("R5 wr0 code", 12'h020, 32'h40);
        rd("R5 rd0 code", 12'h030, 32'h40);
        rd("R6 masked status zero", 12'h01C, 32'h0);

        // R5 R6 R7: fire with enable set
        wr(12'h020, 32'h1111_1111);
        wr(12'h030, 32'h2222_2222);
        wr(12'h018, 32'h1);
        wr(12'h008, 32'h1);
        check("R7 irq same edge", {31'b0, irq}, 32'h1);
        rd("R6 status done", 12'h01C, 32'h1);
        rd("R5 wr0 code again", 12'h020, 32'h40);
        rd("R5 rd0 code again", 12'h030, 32'h40);

        // R8: refused while pending
        wr(12'h020, 32'h3333_3333);
        wr(12'h030, 32'h4444_4444);
        wr(12'h008, 32'hFFFF_FFFF);
        rd("R8 wr0 kept", 12'h020, 32'h3333_3333);
        rd("R8 rd0 kept", 12'h030, 32'h4444_4444);
        rd("R8 status kept", 12'h01C, 32'h1);
        irq_is("R8 irq kept", 1'b1);

        // R10: enable change does not drop irq
        wr(12'h018, 32'h0);
        irq_is("R10 irq holds", 1'b1);
        rd("R10 status holds", 12'h01C, 32'h1);

        // R9: write-one-to-clear
        wr(12'h01C, 32'hFFFF_FFFE);
        rd("R9 zero bits keep", 12'h01C, 32'h1);
        irq_is("R9 irq still high", 1'b1);
        wr(12'h01C, 32'h1);
        check("R9 irq drops", {31'b0, irq}, 32'h0);
        rd("R9 status cleared", 12'h01C, 32'h0);

        // R6: only bit 0 can become set
        wr(12'h018, 32'hFFFF_FFFF);
        wr(12'h030, 32'h5555_5555);
        wr(12'h008, 32'h1);
        rd("R6 only bit0", 12'h01C, 32'h1);
        rd("R5 after clear", 12'h030, 32'h40);
        irq_is("R7 irq full mask", 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule